// File: doc/BRIEF.md
# Random Word Generator Register Front End

This block sits between a simple 32-bit register bus and a random bit source. Software sets the generator enable and picks a mode. In true-random mode, bits come from up to four external entropy lanes that share one valid strobe. In pseudo-random mode, bits come from an internal 32-bit linear feedback shift register that software can reseed. The block packs the generated bits into 32-bit words. When a batch of eight words is complete it raises a data-ready flag. Software then reads the words one at a time through the data register.

Status flags are cleared by writing 1 to them. Clearing data-ready throws away the rest of the current batch and starts a new one. An interrupt output combines the status flags with per-source enables and a global enable. Bus reads are registered: read data appears in the cycle after the read strobe and keeps its value until the next read.

Top module: `rng_frontend`

## Requirements
- R1: After reset, every register reads 0, the interrupt output is 0, and the generator is idle.
- R2: The control register is at offset 0x00. Its fields are: bit 0 generator enable, bits 7:4 entropy lane enables (bit 4 is lane 0), bit 16 ready-interrupt enable, bit 17 error-interrupt enable, bit 24 global interrupt enable. Only these bits are stored. Writing all ones reads back as 0x010300F1. Every register read returns its value in the cycle after the read strobe.
- R3: Conditions for a true-random bit: the block is enabled, the mode register at offset 0x04 has bit 0 clear, data-ready is clear, at least one lane is enabled, and the valid strobe is high. When all of these hold, the block takes one bit equal to the XOR of the entropy lanes masked by the lane enables. Bits are packed so that the first bit of a word ends up in bit 31. Data-ready (status register 0x08, bit 1) is set once 256 bits have been collected, and not before.
- R4: Each read of the data register at offset 0x0C returns the next word of the ready batch, in the order the words were generated. While data-ready is set, generation is paused, and further entropy strobes do not change the batch.
- R5: A data register read returns 0 and sets the error flag (status bit 3) when no unread word of a ready batch is left.
- R6: Status bits 0, 1 and 3 are cleared by writing 1 to them. Writing 0 to a status bit leaves it unchanged. If a flag is set and cleared in the same cycle, the set wins.
- R7: Clearing data-ready while it is set discards the unread words and any partly built word, and a new batch starts from the next generated bit.
- R8: Suppose the block is enabled in true-random mode with no lane enabled and data-ready clear. Then no bits are collected, and the error flag is set in every such cycle.
- R9: Pseudo-random mode (mode bit 0 set) yields one bit per cycle while the block is enabled and data-ready is clear. The bit is bit 0 of the LFSR state. The LFSR then steps in right-shifting Galois form: the state is shifted right by one and, if the output bit was 1, XORed with mask 0x80200003. Writing 1 to bit 0 of the reseed register at offset 0x40 loads a seed instead of stepping. The seed is the last 32 capture bits, newest in bit 0. A capture bit is taken on every valid strobe and equals the XOR of all four lanes. The reseed register reads 0.
- R10: The LFSR state after reset is 0x00000001. An all-zero seed is replaced by 0x00000001, so the state is never zero.
- R11: The interrupt output equals: global enable AND ((ready enable AND data-ready) OR (error enable AND (error OR health-failure))).
- R12: A high level on the health-failure input sets status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Register byte offset |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_ren | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| ent_bits | input | 4 | One entropy bit per lane |
| ent_vld | input | 1 | Qualifies ent_bits for one cycle |
| hlth_fail | input | 1 | External health-test failure indication |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume the following about the inputs:
- Each bus access is a single-cycle strobe to one offset.
- Entropy lanes matter only in cycles where the valid strobe is high.
- The reset input is the only reset source, so the LFSR and the status flags start from their reset values.

The stimulus keeps within these assumptions:
- It drives every strobe for exactly one cycle, between clock edges.
- It raises the entropy valid strobe only while feeding a counted run of bits.
- It reseeds and changes mode only while the generator is disabled, so every expected batch follows from a known bit stream or a known seed.

// File: rtl/rng_fe_pkg.sv
package rng_fe_pkg;
  // register byte offsets, fixed because software decodes them
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_MODE = 8'h04;
  localparam logic [7:0] OFS_STAT = 8'h08;
  localparam logic [7:0] OFS_DATA = 8'h0C;
  localparam logic [7:0] OFS_SEED = 8'h40;

  // control field positions
  localparam int unsigned CB_EN     = 0;
  localparam int unsigned CB_SRC_LO = 4;
  localparam int unsigned CB_DIE    = 16;
  localparam int unsigned CB_EIE    = 17;
  localparam int unsigned CB_GIE    = 24;

  // status field positions
  localparam int unsigned SB_HF  = 0;
  localparam int unsigned SB_RDY = 1;
  localparam int unsigned SB_ERR = 3;

  typedef enum logic {
    MODE_TRUE   = 1'b0,
    MODE_PSEUDO = 1'b1
  } gen_mode_e;
endpackage

// File: rtl/rng_fe_lfsr.sv
module rng_fe_lfsr #(
  parameter int unsigned   W     = 32,
  parameter logic [W-1:0]  TAPS  = 32'h8020_0003,
  parameter logic [W-1:0]  SUBST = 32'h0000_0001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         load,
  input  logic [W-1:0] seed_i,
  output logic         bit_o
);
  logic [W-1:0] st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (load) begin
      st_d = (seed_i == '0) ? SUBST : seed_i;
    end else if (step) begin
      st_d = st_q[0] ? ((st_q >> 1) ^ TAPS) : (st_q >> 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SUBST;
    end else if (load || step) begin
      st_q <= st_d;
    end
  end

  assign bit_o = st_q[0];
endmodule

// File: rtl/rng_fe_collect.sv
module rng_fe_collect #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         bit_vld,
  input  logic         bit_i,
  output logic         word_vld,
  output logic [W-1:0] word_o
);
  localparam int unsigned CW = $clog2(W);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-2:0]  acc_q, acc_d;
  logic          last;

  assign last     = (cnt_q == CW'(W - 1));
  assign word_o   = {acc_q, bit_i};
  assign word_vld = bit_vld && last && !clr;

  always_comb begin
    cnt_d = cnt_q;
    acc_d = acc_q;
    if (clr) begin
      cnt_d = '0;
    end else if (bit_vld) begin
      acc_d = word_o[W-2:0];
      cnt_d = last ? '0 : cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (clr || bit_vld) begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
    end
  end
endmodule

// File: rtl/rng_fe_wbuf.sv
module rng_fe_wbuf #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic         full_evt,
  output logic         avail,
  output logic [W-1:0] dout
);
  localparam int unsigned PW = $clog2(DEPTH + 1);
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PW-1:0]             wcnt_q, wcnt_d, rcnt_q, rcnt_d;
  logic [DEPTH-1:0][W-1:0]   slot_w;
  logic                      wr_ok;

  assign wr_ok    = push && !flush && (wcnt_q != PW'(DEPTH));
  assign full_evt = wr_ok && (wcnt_q == PW'(DEPTH - 1));
  assign avail    = (wcnt_q == PW'(DEPTH)) && (rcnt_q != PW'(DEPTH));
  assign dout     = slot_w[rcnt_q[IW-1:0]];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic [W-1:0] ent_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else if (wr_ok && (wcnt_q == PW'(gi))) begin
        ent_q <= din;
      end
    end
    assign slot_w[gi] = ent_q;
  end

  always_comb begin
    wcnt_d = wcnt_q;
    rcnt_d = rcnt_q;
    if (flush) begin
      wcnt_d = '0;
      rcnt_d = '0;
    end else begin
      if (wr_ok)         wcnt_d = wcnt_q + PW'(1);
      if (pop && avail)  rcnt_d = rcnt_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
      rcnt_q <= '0;
    end else if (flush || wr_ok || (pop && avail)) begin
      wcnt_q <= wcnt_d;
      rcnt_q <= rcnt_d;
    end
  end
endmodule

// File: rtl/rng_frontend.sv
module rng_frontend #(
  parameter int unsigned DW        = 32,
  parameter int unsigned BATCH     = 8,
  parameter int unsigned LANES     = 4,
  parameter logic [31:0] LFSR_TAPS = 32'h8020_0003,
  parameter logic [31:0] SEED_SUB  = 32'h0000_0001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       bus_addr,
  input  logic             bus_wen,
  input  logic [DW-1:0]    bus_wdata,
  input  logic             bus_ren,
  output logic [DW-1:0]    bus_rdata,
  input  logic [LANES-1:0] ent_bits,
  input  logic             ent_vld,
  input  logic             hlth_fail,
  output logic             irq
);
  import rng_fe_pkg::*;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rsync_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  // address decode
  logic hit_ctl, hit_mode, hit_stat, hit_data, hit_seed;
  assign hit_ctl  = (bus_addr == OFS_CTRL);
  assign hit_mode = (bus_addr == OFS_MODE);
  assign hit_stat = (bus_addr == OFS_STAT);
  assign hit_data = (bus_addr == OFS_DATA);
  assign hit_seed = (bus_addr == OFS_SEED);

  logic wr_ctl, wr_mode, wr_stat, reseed, pop;
  assign wr_ctl  = bus_wen && hit_ctl;
  assign wr_mode = bus_wen && hit_mode;
  assign wr_stat = bus_wen && hit_stat;
  assign reseed  = bus_wen && hit_seed && bus_wdata[0];
  assign pop     = bus_ren && hit_data;

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  // control and mode registers
  logic             en_q, en_d, die_q, die_d, eie_q, eie_d, gie_q, gie_d;
  logic [LANES-1:0] src_q, src_d;
  gen_mode_e        mode_q, mode_d;

  always_comb begin
    en_d   = en_q;
    src_d  = src_q;
    die_d  = die_q;
    eie_d  = eie_q;
    gie_d  = gie_q;
    mode_d = mode_q;
    if (wr_ctl) begin
      en_d  = bus_wdata[CB_EN];
      src_d = bus_wdata[CB_SRC_LO +: LANES];
      die_d = bus_wdata[CB_DIE];
      eie_d = bus_wdata[CB_EIE];
      gie_d = bus_wdata[CB_GIE];
    end
    if (wr_mode) mode_d = gen_mode_e'(bus_wdata[0]);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      en_q  <= 1'b0;
      src_q <= '0;
      die_q <= 1'b0;
      eie_q <= 1'b0;
      gie_q <= 1'b0;
    end else if (wr_ctl) begin
      en_q  <= en_d;
      src_q <= src_d;
      die_q <= die_d;
      eie_q <= eie_d;
      gie_q <= gie_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      mode_q <= MODE_TRUE;
    else if (wr_mode) mode_q <= mode_d;
  end

  // seed capture from every strobe, all lanes folded
  logic [DW-1:0] cap_q, cap_d;
  assign cap_d = {cap_q[DW-2:0], ^ent_bits};
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      cap_q <= '0;
    else if (ent_vld) cap_q <= cap_d;
  end

  // bit generation
  logic hf_q, rdy_q, err_q;
  logic collecting, no_src, trng_vld, prng_step, gen_vld, gen_bit, lfsr_bit;
  logic src_mix;

  assign src_mix    = ^(ent_bits & src_q);
  assign no_src     = (src_q == '0);
  assign collecting = en_q && !rdy_q;
  assign trng_vld   = collecting && (mode_q == MODE_TRUE) && !no_src && ent_vld;
  assign prng_step  = collecting && (mode_q == MODE_PSEUDO) && !reseed;
  assign gen_vld    = trng_vld || prng_step;
  assign gen_bit    = (mode_q == MODE_PSEUDO) ? lfsr_bit : src_mix;

  rng_fe_lfsr #(
    .W     (DW),
    .TAPS  (LFSR_TAPS),
    .SUBST (SEED_SUB)
  ) u_lfsr (
    .clk    (clk),
    .rst_n  (srst_n),
    .step   (prng_step),
    .load   (reseed),
    .seed_i (cap_q),
    .bit_o  (lfsr_bit)
  );

  logic          clr_hf, clr_rdy, clr_err, flush;
  logic          word_vld, full_evt, buf_avail;
  logic [DW-1:0] word, buf_dout;

  assign clr_hf  = wr_stat && bus_wdata[SB_HF];
  assign clr_rdy = wr_stat && bus_wdata[SB_RDY];
  assign clr_err = wr_stat && bus_wdata[SB_ERR];
  assign flush   = clr_rdy && rdy_q;

  rng_fe_collect #(.W(DW)) u_coll (
    .clk      (clk),
    .rst_n    (srst_n),
    .clr      (flush),
    .bit_vld  (gen_vld),
    .bit_i    (gen_bit),
    .word_vld (word_vld),
    .word_o   (word)
  );

  rng_fe_wbuf #(.W(DW), .DEPTH(BATCH)) u_buf (
    .clk      (clk),
    .rst_n    (srst_n),
    .flush    (flush),
    .push     (word_vld),
    .din      (word),
    .pop      (pop),
    .full_evt (full_evt),
    .avail    (buf_avail),
    .dout     (buf_dout)
  );

  // status flags: set events take priority over write-one clears
  logic hf_d, rdy_d, err_d, err_set;
  assign err_set = (collecting && (mode_q == MODE_TRUE) && no_src) || (pop && !buf_avail);

  always_comb begin
    hf_d  = hf_q;
    rdy_d = rdy_q;
    err_d = err_q;
    if (clr_hf)    hf_d  = 1'b0;
    if (hlth_fail) hf_d  = 1'b1;
    if (clr_rdy)   rdy_d = 1'b0;
    if (full_evt)  rdy_d = 1'b1;
    if (clr_err)   err_d = 1'b0;
    if (err_set)   err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      hf_q  <= 1'b0;
      rdy_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      hf_q  <= hf_d;
      rdy_q <= rdy_d;
      err_q <= err_d;
    end
  end

  // read path, registered
  logic [DW-1:0] ctl_word, stat_word, rdata_d, rdata_q;

  always_comb begin
    ctl_word                      = '0;
    ctl_word[CB_EN]               = en_q;
    ctl_word[CB_SRC_LO +: LANES]  = src_q;
    ctl_word[CB_DIE]              = die_q;
    ctl_word[CB_EIE]              = eie_q;
    ctl_word[CB_GIE]              = gie_q;
    stat_word                     = '0;
    stat_word[SB_HF]              = hf_q;
    stat_word[SB_RDY]             = rdy_q;
    stat_word[SB_ERR]             = err_q;
  end

  always_comb begin
    rdata_d = '0;
    case (bus_addr)
      OFS_CTRL: rdata_d = ctl_word;
      OFS_MODE: rdata_d = DW'(mode_q);
      OFS_STAT: rdata_d = stat_word;
      OFS_DATA: rdata_d = buf_avail ? buf_dout : '0;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      rdata_q <= '0;
    else if (bus_ren) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
  assign irq       = gie_q && ((die_q && rdy_q) || (eie_q && (err_q || hf_q)));
endmodule

// File: rtl/rng_frontend_chk.sv
module rng_frontend_chk #(
  parameter int unsigned DW    = 32,
  parameter int unsigned LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       bus_addr,
  input logic             bus_wen,
  input logic             bus_ren,
  input logic             wd_rdy,
  input logic             wd_err,
  input logic [DW-1:0]    bus_rdata,
  input logic             irq,
  input logic             gie,
  input logic             en,
  input logic             mode,
  input logic [LANES-1:0] src,
  input logic             rdy,
  input logic             err
);
  import rng_fe_pkg::*;

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> gie);                                                           // R11

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ren && bus_addr == OFS_DATA && !rdy) |=> (bus_rdata == '0));       // R5

  AST_EMPTY_READ_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ren && bus_addr == OFS_DATA && !rdy) |=> err);                     // R5

  AST_NOSRC_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !mode && src == '0 && !rdy) |=> !rdy);                           // R8

  AST_NOSRC_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !mode && src == '0 && !rdy) |=> err);                            // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(bus_wen && bus_addr == OFS_STAT && wd_err)) |=> err);         // R6

  AST_RDY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && !(bus_wen && bus_addr == OFS_STAT && wd_rdy)) |=> rdy);         // R6

  AST_RDY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> $past(en));                                              // R3
endmodule

module rng_fe_lfsr_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] st
);
  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    st != '0);                                                              // R10
endmodule

bind rng_frontend rng_frontend_chk #(.DW(DW), .LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wen   (bus_wen),
  .bus_ren   (bus_ren),
  .wd_rdy    (bus_wdata[1]),
  .wd_err    (bus_wdata[3]),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .gie       (gie_q),
  .en        (en_q),
  .mode      (mode_q),
  .src       (src_q),
  .rdy       (rdy_q),
  .err       (err_q)
);

bind rng_fe_lfsr rng_fe_lfsr_chk #(.W(W)) u_lchk (
  .clk   (clk),
  .rst_n (rst_n),
  .st    (st_q)
);

// File: tb/sim_rng_frontend.sv
module sim_rng_frontend;
  import rng_fe_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wen = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ren = 1'b0;
  logic [31:0] bus_rdata;
  logic [3:0]  ent_bits = '0;
  logic        ent_vld = 1'b0;
  logic        hlth_fail = 1'b0;
  logic        irq;

  rng_frontend u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wen   (bus_wen),
    .bus_wdata (bus_wdata),
    .bus_ren   (bus_ren),
    .bus_rdata (bus_rdata),
    .ent_bits  (ent_bits),
    .ent_vld   (ent_vld),
    .hlth_fail (hlth_fail),
    .irq       (irq)
  );

  always #4 clk = ~clk;

  int          checks = 0;
  int          errs = 0;
  bit          done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] exp_w[8];
  logic [31:0] acc = '0;
  logic [31:0] cap = '0;
  logic [31:0] lcg = 32'h1234_5678;
  int          mcnt = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares each read result with the queued expectation
  logic rd_pend = 1'b0;
  always @(posedge clk) rd_pend <= bus_ren;
  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "monitor", bus_rdata, 32'h0);
      end else begin
        logic [31:0] e;
        string       t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(bus_rdata == e, t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_addr = a; bus_ren = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_ren = 1'b0;
  endtask

  task automatic feed(input int n, input logic [3:0] m, input bit coll, input bit zero);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      ent_bits = zero ? 4'h0 : lcg[27:24];
      ent_vld = 1'b1;
      cap = {cap[30:0], ^ent_bits};
      if (coll && mcnt < 256) begin
        acc = {acc[30:0], ^(ent_bits & m)};
        mcnt++;
        if (mcnt % 32 == 0) exp_w[mcnt/32 - 1] = acc;
      end
    end
    @(negedge clk);
    ent_vld = 1'b0;
  endtask

  task automatic prng_model(input logic [31:0] seed);
    logic [31:0] s;
    s = seed;
    for (int w = 0; w < 8; w++) begin
      for (int b = 0; b < 32; b++) begin
        acc = {acc[30:0], s[0]};
        s = s[0] ? ((s >> 1) ^ 32'h8020_0003) : (s >> 1);
      end
      exp_w[w] = acc;
    end
  endtask

  task automatic read_batch(input string t);
    for (int k = 0; k < 8; k++) rd(OFS_DATA, exp_w[k], t);
  endtask

  task automatic pulse_hf();
    @(negedge clk); hlth_fail = 1'b1;
    @(negedge clk); hlth_fail = 1'b0;
  endtask

  initial begin
    logic [31:0] seed;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(irq == 1'b0, "R1 irq", {31'b0, irq}, 32'h0);
    rd(OFS_CTRL, 32'h0, "R1 ctrl");
    rd(OFS_MODE, 32'h0, "R1 mode");
    rd(OFS_STAT, 32'h0, "R1 stat");
    rd(OFS_SEED, 32'h0, "R1 seed");

    // R2 implemented control bits only
    wr(OFS_CTRL, 32'hFFFF_FFFF);
    rd(OFS_CTRL, 32'h0103_00F1, "R2 ctrl");
    chk(irq == 1'b0, "R2 irq idle", {31'b0, irq}, 32'h0);
    wr(OFS_CTRL, 32'h0);

    // R12 health failure flag, cleared by writing one
    pulse_hf();
    rd(OFS_STAT, 32'h1, "R12 hf set");
    wr(OFS_STAT, 32'h1);
    rd(OFS_STAT, 32'h0, "R12 hf cleared");

    // R3 true-random batch over lanes 0 and 2
    mcnt = 0;
    wr(OFS_CTRL, 32'h0000_0051);
    feed(255, 4'b0101, 1'b1, 1'b0);
    rd(OFS_STAT, 32'h0, "R3 not ready at 255");
    feed(1, 4'b0101, 1'b1, 1'b0);
    rd(OFS_STAT, 32'h2, "R3 ready at 256");
    // R4 strobes while ready leave the batch alone
    feed(10, 4'b0101, 1'b0, 1'b0);
    read_batch("R4");
    // R5 empty read
    rd(OFS_DATA, 32'h0, "R5 empty data");
    rd(OFS_STAT, 32'hA, "R5 err set");

    // R6 write-one-to-clear
    wr(OFS_STAT, 32'h0);
    rd(OFS_STAT, 32'hA, "R6 zero write");
    wr(OFS_STAT, 32'h8);
    rd(OFS_STAT, 32'h2, "R6 err only");
    wr(OFS_STAT, 32'h2);
    rd(OFS_STAT, 32'h0, "R6 rdy cleared");
    rd(OFS_DATA, 32'h0, "R7 discarded");
    wr(OFS_STAT, 32'h8);

    // R7 new batch over all lanes
    mcnt = 0;
    wr(OFS_CTRL, 32'h0000_00F1);
    feed(256, 4'b1111, 1'b1, 1'b0);
    rd(OFS_STAT, 32'h2, "R7 ready");
    read_batch("R7");

    // R11 ready interrupt path
    wr(OFS_CTRL, 32'h0101_00F1);
    chk(irq == 1'b1, "R11 ready irq", {31'b0, irq}, 32'h1);
    wr(OFS_CTRL, 32'h0001_00F1);
    chk(irq == 1'b0, "R11 global off", {31'b0, irq}, 32'h0);
    wr(OFS_CTRL, 32'h0);
    wr(OFS_STAT, 32'h2);
    rd(OFS_STAT, 32'h0, "R7 cleared");

    // R8 no lanes enabled
    wr(OFS_CTRL, 32'h0102_0001);
    feed(300, 4'b0000, 1'b0, 1'b0);
    rd(OFS_STAT, 32'h8, "R8 err no data");
    chk(irq == 1'b1, "R11 err irq", {31'b0, irq}, 32'h1);
    wr(OFS_STAT, 32'h8);
    rd(OFS_STAT, 32'h8, "R6 set wins");
    wr(OFS_CTRL, 32'h0);
    wr(OFS_STAT, 32'h8);
    rd(OFS_STAT, 32'h0, "R8 cleared");

    // R11 health failure interrupt path
    wr(OFS_CTRL, 32'h0102_0000);
    pulse_hf();
    chk(irq == 1'b1, "R11 hf irq", {31'b0, irq}, 32'h1);
    wr(OFS_STAT, 32'h1);
    chk(irq == 1'b0, "R11 hf cleared", {31'b0, irq}, 32'h0);
    wr(OFS_CTRL, 32'h0);

    // R9 pseudo-random batch from captured seed
    wr(OFS_MODE, 32'h1);
    rd(OFS_MODE, 32'h1, "R9 mode");
    feed(32, 4'b0000, 1'b0, 1'b0);
    seed = (cap == 32'h0) ? 32'h1 : cap;
    wr(OFS_SEED, 32'h1);
    prng_model(seed);
    wr(OFS_CTRL, 32'h1);
    repeat (300) @(negedge clk);
    rd(OFS_STAT, 32'h2, "R9 ready");
    read_batch("R9");
    wr(OFS_CTRL, 32'h0);
    wr(OFS_STAT, 32'h2);

    // R10 all-zero seed substituted
    feed(32, 4'b0000, 1'b0, 1'b1);
    wr(OFS_SEED, 32'h1);
    prng_model(32'h1);
    wr(OFS_CTRL, 32'h1);
    repeat (300) @(negedge clk);
    rd(OFS_STAT, 32'h2, "R10 ready");
    read_batch("R10");

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errs++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("  CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end
endmodule